// File: doc/BRIEF.md
# Octal DAC Serial Command Interface

This block is the digital front end of an eight-channel voltage-output converter. A host shifts frames into it over a three-wire serial link: a clock, a data input and an active-low line that both selects the device and loads the frame. While the select line is low, each rising edge of the serial clock takes one data bit. When the line goes high again, the block acts on the frame. It looks at the last 24 bits received, which hold a 4-bit operation, a 4-bit channel address and a 16-bit code, in that order and MSB first.

Each channel has two registers. The input register is a staging register. The DAC register holds the code the converter actually drives. An operation can stage a code, move staged codes into the DAC registers, do both at once, or put a channel to sleep. Each channel also has a power-down request, and any operation that loads a channel's DAC register clears that channel's request.

A 32-bit frame carries eight filler bits in front of the 24-bit word. Devices are chained by wiring one device's serial output to the next device's data input. The serial output replays the bits received before the current frame, MSB first, and changes after each falling clock edge. When the resolution is set to 14 or 12 bits, the code stays MSB-aligned in its 16-bit field and the unused low bits are stored as zero.

All three serial inputs are resynchronised to the system clock `clk` before use. The serial clock must therefore be well below half the system clock rate.

Top module: `octal_dac_serial_if`

## Requirements
- R1: After reset, every DAC code is 0, every power-down request is 1, no update strobe is high and the serial output is 0.
- R2: A frame of exactly 24 bits with operation 4'h3 writes the code into the addressed channel's input register and its DAC register. That channel's update strobe gives one pulse and its power-down request clears.
- R3: Operation 4'h0 stages the code in the input register only, and the DAC outputs do not change. Operation 4'h1 then copies the staged code of the addressed channel into its DAC register, pulses its strobe and powers it up.
- R4: Operation 4'h2 writes the addressed input register(s). It then loads every DAC register from the input registers, including the new value, pulses all eight strobes and powers up all channels.
- R5: Operation 4'h4 sets the power-down request of the addressed channel(s). DAC codes and strobes stay as they were.
- R6: Address values 0 to 7 select channels A to H. Address 4'hF selects all eight channels. A frame with address 8 to 14 changes nothing. Operation 4'hF, and any operation not listed in R2 to R5, changes nothing.
- R7: In a 32-bit frame the first eight bits are ignored. The frame acts exactly as the 24-bit word that follows them.
- R8: A frame with fewer than 24 rising clock edges before the select line rises is discarded. No register, strobe or power-down request changes.
- R9: While the select line is low, the serial output presents, MSB first, the 32 most recent bits received before the current frame. It presents the first bit once the select line falls and the next bit after each falling clock edge.
- R10: With resolution RES_BITS below 16, the low 16-RES_BITS bits of every stored code read as zero. The upper bits keep their positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| cs_ld | input | 1 | Active-low select; its rising edge loads the frame |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out for daisy-chaining |
| dac_code | output | 128 | Eight 16-bit DAC register values, channel A in bits 15:0 |
| upd_strobe | output | 8 | One-cycle pulse per channel when its DAC register is loaded |
| pwr_dn | output | 8 | Per-channel power-down request |

## Verification
The hardest case to reach from the ports is a channel whose DAC register must not move while other state around it changes. Examples are a staged write after a power-down, a frame cut off after 20 bits, or a write with an unused address. Each of these looks the same at the outputs as an operation that did nothing.

The bench therefore pairs directed sequences with constrained-random frames, and compares all eight codes, requests and strobe counts after every frame. The directed sequences stage a code, then cut a frame short, then update. The random frames mix short, 24-bit and 32-bit lengths with every operation and address.

The serial output is checked bit by bit against a model of the received-bit history that is carried across every frame, short ones included. A second instance set to 12-bit resolution watches the same bus to check the alignment of the stored codes.

// File: rtl/dac_serial_pkg.sv
package dac_serial_pkg;
  localparam int NCH       = 8;
  localparam int CODE_W    = 16;
  localparam int FRAME_MIN = 24;
  localparam int FRAME_MAX = 32;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [3:0] {
    OP_STAGE      = 4'h0,
    OP_LOAD       = 4'h1,
    OP_STAGE_ALL  = 4'h2,
    OP_STAGE_LOAD = 4'h3,
    OP_SLEEP      = 4'h4,
    OP_IDLE       = 4'hF
  } op_e;

  // Channels selected by an address field: one channel, all, or none.
  function automatic logic [NCH-1:0] chan_mask(input logic [3:0] addr);
    logic [NCH-1:0] m;
    m = '0;
    if (addr == 4'hF) m = '1;
    else if (int'(addr) < NCH) m[addr[2:0]] = 1'b1;
    return m;
  endfunction

  // Keep the top res bits of a code, clear the rest.
  function automatic logic [CODE_W-1:0] align_code(input logic [CODE_W-1:0] d, input int res);
    logic [CODE_W-1:0] r;
    for (int i = 0; i < CODE_W; i++) r[i] = (i >= CODE_W - res) ? d[i] : 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      dout <= RST_VAL;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift
  import dac_serial_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_s,
  input  logic        cs_s,
  input  logic        sdi_s,
  output logic        sdo,
  output logic        frame_ok,
  output logic        frame_short,
  output logic [23:0] word
);
  logic                 sck_q, cs_q;
  logic [FRAME_MAX-1:0] sreg;
  logic [CNT_W-1:0]     nbits;

  // Named events, used by the logic and by the assertions.
  wire sck_rise = sck_s & ~sck_q & ~cs_s;
  wire sck_fall = ~sck_s & sck_q & ~cs_s;
  wire cs_fall  = ~cs_s & cs_q;
  wire cs_rise  = cs_s & ~cs_q;
  wire long_enough = (nbits >= CNT_W'(FRAME_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      sreg  <= '0;
      nbits <= '0;
      sdo   <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      if (cs_fall) nbits <= '0;
      else if (sck_rise) begin
        sreg <= {sreg[FRAME_MAX-2:0], sdi_s};
        if (nbits < CNT_W'(FRAME_MAX)) nbits <= nbits + 1'b1;
      end
      if (cs_fall || sck_fall) sdo <= sreg[FRAME_MAX-1];
    end
  end

  assign frame_ok    = cs_rise & long_enough;
  assign frame_short = cs_rise & ~long_enough;
  assign word        = sreg[23:0];

  p_sdo_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sck_fall || cs_fall));
  p_bits_only_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s && cs_q |=> $stable(nbits));
endmodule

// File: rtl/dac_channel_bank.sv
module dac_channel_bank
  import dac_serial_pkg::*;
#(
  parameter int RES_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [3:0]            op,
  input  logic [3:0]            addr,
  input  logic [CODE_W-1:0]     data,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [NCH-1:0]        upd_strobe,
  output logic [NCH-1:0]        pwr_dn
);
  logic [CODE_W-1:0] in_reg  [NCH];
  logic [CODE_W-1:0] dac_reg [NCH];

  wire [NCH-1:0]    sel  = chan_mask(addr);
  wire [CODE_W-1:0] code = align_code(data, RES_BITS);
  wire              act  = commit && (sel != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        in_reg[i]  <= '0;
        dac_reg[i] <= '0;
      end
      upd_strobe <= '0;
      pwr_dn     <= '1;
    end else begin
      upd_strobe <= '0;
      if (act) begin
        for (int i = 0; i < NCH; i++) begin
          case (op)
            OP_STAGE: if (sel[i]) in_reg[i] <= code;
            OP_LOAD: if (sel[i]) begin
              dac_reg[i]    <= in_reg[i];
              upd_strobe[i] <= 1'b1;
              pwr_dn[i]     <= 1'b0;
            end
            OP_STAGE_ALL: begin
              if (sel[i]) in_reg[i] <= code;
              dac_reg[i]    <= sel[i] ? code : in_reg[i];
              upd_strobe[i] <= 1'b1;
              pwr_dn[i]     <= 1'b0;
            end
            OP_STAGE_LOAD: if (sel[i]) begin
              in_reg[i]     <= code;
              dac_reg[i]    <= code;
              upd_strobe[i] <= 1'b1;
              pwr_dn[i]     <= 1'b0;
            end
            OP_SLEEP: if (sel[i]) pwr_dn[i] <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  p_strobe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe != '0) |-> $past(commit));

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign dac_code[g*CODE_W +: CODE_W] = dac_reg[g];
    p_code_moves_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_reg[g]) |-> upd_strobe[g]);
    p_update_wakes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_strobe[g] |-> !pwr_dn[g]);
  end
endmodule

// File: rtl/octal_dac_serial_if.sv
module octal_dac_serial_if
  import dac_serial_pkg::*;
#(
  parameter int RES_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck,
  input  logic                  cs_ld,
  input  logic                  sdi,
  output logic                  sdo,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [NCH-1:0]        upd_strobe,
  output logic [NCH-1:0]        pwr_dn
);
  logic [2:0]  pins_s;
  logic        frame_ok, frame_short;
  logic [23:0] word;

  dac_in_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sck, cs_ld, sdi}), .dout(pins_s));

  dac_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sck_s(pins_s[2]), .cs_s(pins_s[1]), .sdi_s(pins_s[0]),
    .sdo(sdo), .frame_ok(frame_ok), .frame_short(frame_short), .word(word));

  dac_channel_bank #(.RES_BITS(RES_BITS)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(frame_ok),
    .op(word[23:20]), .addr(word[19:16]), .data(word[15:0]),
    .dac_code(dac_code), .upd_strobe(upd_strobe), .pwr_dn(pwr_dn));

  p_short_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_short |=> (upd_strobe == '0) && $stable(pwr_dn) && $stable(dac_code));
endmodule

// File: tb/octal_dac_serial_if_test.sv
module octal_dac_serial_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6 * CLK_PERIOD;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_ld = 1'b1, sdi = 1'b0;
  logic sdo, sdo12;
  logic [127:0] code16, code12;
  logic [7:0] strb, strb12, pd, pd12;

  octal_dac_serial_if #(.RES_BITS(16)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_ld(cs_ld), .sdi(sdi), .sdo(sdo),
    .dac_code(code16), .upd_strobe(strb), .pwr_dn(pd));
  octal_dac_serial_if #(.RES_BITS(12)) uut_r12 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_ld(cs_ld), .sdi(sdi), .sdo(sdo12),
    .dac_code(code12), .upd_strobe(strb12), .pwr_dn(pd12));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_in [8];
  logic [15:0] m_dac [8];
  logic [7:0]  m_pd, m_str;
  logic [31:0] m_hist;
  int          str_cnt [8];

  always @(negedge clk)
    for (int i = 0; i < 8; i++) if (strb[i]) str_cnt[i] <= str_cnt[i] + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_sel(input logic [3:0] a);
    if (a == 4'hF) return 8'hFF;
    if (a < 4'd8) return 8'd1 << a;
    return 8'h00;
  endfunction

  function automatic logic [15:0] m_align(input logic [15:0] d, input int res);
    return d & (16'hFFFF << (16 - res));
  endfunction

  task automatic model(input logic [23:0] w);
    logic [3:0] op = w[23:20];
    logic [7:0] s = m_sel(w[19:16]);
    m_str = 8'h00;
    if (s == 8'h00) return;
    for (int i = 0; i < 8; i++) begin
      case (op)
        4'h0: if (s[i]) m_in[i] = w[15:0];
        4'h1: if (s[i]) begin m_dac[i] = m_in[i]; m_pd[i] = 1'b0; m_str[i] = 1'b1; end
        4'h2: begin
          if (s[i]) m_in[i] = w[15:0];
          m_dac[i] = m_in[i]; m_pd[i] = 1'b0; m_str[i] = 1'b1;
        end
        4'h3: if (s[i]) begin m_in[i] = w[15:0]; m_dac[i] = w[15:0]; m_pd[i] = 1'b0; m_str[i] = 1'b1; end
        4'h4: if (s[i]) m_pd[i] = 1'b1;
        default: ;
      endcase
    end
  endtask

  // Shift n bits of w (MSB first); checks the chained output before each rising edge.
  task automatic send(input logic [31:0] w, input int n);
    for (int i = 0; i < 8; i++) str_cnt[i] = 0;
    cs_ld = 1'b0;
    for (int k = n - 1; k >= 0; k--) begin
      sdi = w[k];
      #(HALF);
      chk(sdo === m_hist[31], "R9 sdo bit", {31'd0, sdo}, {31'd0, m_hist[31]});
      m_hist = {m_hist[30:0], w[k]};
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
    #(HALF);
    cs_ld = 1'b1;
    #(4 * HALF);
    if (n >= 24) model(w[23:0]); else m_str = 8'h00;
  endtask

  task automatic compare(input string tag);
    for (int i = 0; i < 8; i++) begin
      chk(code16[i*16 +: 16] === m_dac[i], tag, {16'd0, code16[i*16 +: 16]}, {16'd0, m_dac[i]});
      chk(code12[i*16 +: 16] === m_align(m_dac[i], 12), "R10 12-bit code",
          {16'd0, code12[i*16 +: 16]}, {16'd0, m_align(m_dac[i], 12)});
      chk(str_cnt[i] == int'(m_str[i]), tag, str_cnt[i], {31'd0, m_str[i]});
    end
    chk(pd === m_pd, tag, {24'd0, pd}, {24'd0, m_pd});
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin m_in[i] = '0; m_dac[i] = '0; str_cnt[i] = 0; end
    m_pd = 8'hFF; m_str = 8'h00; m_hist = '0;
    #(5 * CLK_PERIOD + 3);
    chk(code16 === '0 && pd === 8'hFF, "R1 reset codes/pd", {24'd0, pd}, 32'hFF);
    chk(strb === 8'h00 && sdo === 1'b0, "R1 reset strobe/sdo", {23'd0, sdo, strb}, 32'd0);
    rst_n = 1'b1;
    #(4 * CLK_PERIOD);
    chk(code16 === '0 && pd === 8'hFF && sdo === 1'b0, "R1 after release", {24'd0, pd}, 32'hFF);

    send({8'h00, 4'h3, 4'h3, 16'hABCD}, 24);  compare("R2 write+update ch3");
    send({8'h00, 4'h0, 4'h5, 16'h1234}, 24);  compare("R3 stage only ch5");
    send({8'h00, 4'h1, 4'h5, 16'hFFFF}, 20);  compare("R8 short frame dropped");
    send({8'h00, 4'h1, 4'h5, 16'h0000}, 24);  compare("R3 load ch5");
    send({8'h00, 4'h4, 4'h3, 16'h0000}, 24);  compare("R5 sleep ch3 keeps code");
    send({8'h00, 4'h2, 4'h1, 16'h5A5F}, 24);  compare("R4 stage, update all");
    send({8'h00, 4'h3, 4'h9, 16'h7777}, 24);  compare("R6 unused address ignored");
    send({8'h00, 4'h7, 4'h2, 16'h7777}, 24);  compare("R6 unlisted op ignored");
    send({8'h00, 4'hF, 4'hF, 16'h7777}, 24);  compare("R6 idle op");
    send({8'h00, 4'h4, 4'hF, 16'h0000}, 24);  compare("R6 R5 sleep all");
    send({8'hC3, 4'h3, 4'hF, 16'h8001}, 32);  compare("R7 32-bit broadcast write");
    send({8'hA5, 4'h3, 4'h7, 16'h0F0F}, 32);  compare("R7 R9 chained frame");
    send({8'h00, 4'h3, 4'h0, 16'hFFFF}, 23);  compare("R8 23-bit boundary");

    for (int t = 0; t < 70; t++) begin
      logic [31:0] w = $urandom;
      int sel = $urandom_range(0, 9);
      int n = (sel < 2) ? $urandom_range(4, 23) : ((sel < 6) ? 24 : 32);
      int opi = $urandom_range(0, 7);
      logic [3:0] ops [8] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'hF, 4'h3, 4'h0};
      w[23:20] = (opi == 7 && sel == 9) ? 4'h6 : ops[opi];
      if ($urandom_range(0, 3) != 0) w[19:16] = 4'($urandom_range(0, 7));
      send(w, n);
      compare("R2 R3 R4 R5 R6 R7 R8 random frame");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule